// File: doc/BRIEF.md
# Single-Edge Nibble Frame Transmitter

This block turns one sensor sample into a single-edge nibble frame on one output. The output is an open-drain enable: when `drv_low` is high the pin is pulled low, and when it is low the pin is released. A frame has nine pulses in a fixed order: a calibration pulse, a status nibble, six data nibbles and a CRC nibble. Every pulse starts with a fixed low time. The total length of the pulse carries the nibble value, counted in unit-time ticks. The unit-time tick comes from the block clock through a programmable predivider. The predivider has a floor, so the tick can never be shorter than a minimum width.

Frames follow each other with no gap. At the first cycle of each calibration pulse the block captures the sample inputs: output value, temperature code, range code and predivider. It also takes the pending one-shot status flags at that point. Changes to these inputs during a frame therefore only affect the next frame. A fixed delay after the CRC pulse begins its low time, a one-cycle request tells the upstream logic that it may present the next sample. A disable input releases the pin at once, aborts the frame in flight and holds the transmitter idle. When the disable input is released, a fresh frame starts.

Top module: `sent_frame_tx`

## Requirements
- R1: One unit time lasts (2·p+2) clock cycles, where p is the predivider captured at frame start. Values of p below PREDIV_MIN (default 7) are raised to PREDIV_MIN, so p = 0 gives 16 cycles and p = 11 gives 24 cycles.
- R2: Each pulse drives `drv_low` high for exactly LOW_UT (3) unit times from the pulse start, then low until the pulse ends.
- R3: The calibration pulse lasts SYNC_UT (56) unit times. Each nibble pulse lasts NIB_BASE (12) plus the nibble value unit times.
- R4: The pulse order is calibration, status, then data nibbles value[15:12], value[11:8], value[7:4], value[3:0], temp[7:4], temp[3:0], then CRC.
- R5: Status nibble bit 3 is the startup flag and bit 2 is the overvoltage-recovery flag. Bits 1:0 are the range code, except that code 2'b10 is sent as 2'b01.
- R6: The CRC nibble starts from 4'b0101. For each nibble it becomes T[crc XOR nibble], taken over the status nibble and then the six data nibbles in order. T is the table 0,13,7,10,14,3,9,4,1,12,6,11,15,2,8,5 (multiplication by x^4 modulo x^4+x^3+x^2+1).
- R7: Frames run back to back. Value, temperature, range, predivider and flags are captured at the start of the calibration pulse, so input changes during a frame do not alter that frame.
- R8: The startup flag is set by reset and is carried only by the first frame that starts after reset. If that frame is aborted, the flag is sent again in the next frame.
- R9: A falling edge on `ovv_in` arms the overvoltage-recovery flag. It is sent in the next frame that starts, and is cleared from then on unless that frame is aborted.
- R10: While `tx_off` is high, `drv_low` is low in the same cycle, the frame in flight is abandoned and no frame starts. A new frame begins its calibration pulse one cycle after `tx_off` falls.
- R11: `sample_req` is a one-cycle pulse. It is high in the cycle READY_DLY_CYC (720) cycles after `drv_low` first rises for the CRC pulse. An abort cancels a pending request.
- R12: During reset and in the first cycle after reset, `drv_low` and `sample_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (nominally 8 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_value | input | 16 | Output value to transmit |
| sample_temp | input | 8 | Temperature code to transmit |
| range_code | input | 2 | Measurement range code for the status nibble |
| ovv_in | input | 1 | Overvoltage condition; its falling edge arms the recovery flag |
| tx_off | input | 1 | Forces the output released and suppresses frames |
| prediv | input | 4 | Unit-time predivider |
| drv_low | output | 1 | Open-drain enable, 1 = pull pin low |
| sample_req | output | 1 | One-cycle request for the next sample |

## Verification
Several properties are checked on every cycle by assertions. Ticks never fall on adjacent cycles, and the captured predivider never drops below its floor. The unit counter stays inside the current pulse length, and every rise of the output falls on a pulse start. The captured frame does not change while the frame is in flight. The disable input empties the sequencer on the next cycle. A flag edge always leaves the recovery flag pending. The sample request never lasts two cycles. Only the bench scenarios can show the rest, because it depends on values: the exact pulse widths for each nibble value, the clamped tick length, the CRC nibble contents, the one-shot lifetime of each status flag across aborts, and the exact cycle of the sample request.

// File: rtl/sent_tx_pkg.sv
`timescale 1ns/1ps
package sent_tx_pkg;

   localparam int            NIB_W     = 4;
   localparam logic [3:0]    CRC_SEED  = 4'b0101;
   localparam logic [4:0]    CRC_POLY  = 5'b11101;

   typedef struct packed {
      logic       startup;
      logic       ovr_rec;
      logic [1:0] rng;
   } status_nib_t;

   // One nibble of the CRC: (acc ^ nib) * x^4 mod poly
   function automatic logic [3:0] crc4_step(input logic [3:0] acc, input logic [3:0] nib);
      logic [4:0] v;
      v = {1'b0, acc ^ nib};
      for (int b = 0; b < 4; b++) begin
         v = v << 1;
         if (v[4]) v = v ^ CRC_POLY;
      end
      return v[3:0];
   endfunction

endpackage

// File: rtl/sent_ut_tick.sv
`timescale 1ns/1ps
module sent_ut_tick #(
   parameter int PREDIV_W   = 4,
   parameter int PREDIV_MIN = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [PREDIV_W-1:0] prediv_in,
   input  logic                run,
   output logic                tick
);
   localparam int DIV_W = PREDIV_W + 2;

   if (PREDIV_MIN >= (1 << PREDIV_W)) begin : g_bad_min
      $error("PREDIV_MIN does not fit in PREDIV_W bits");
   end

   logic [PREDIV_W-1:0] eff;
   logic [DIV_W-1:0]    per_q, div_q;

   if (PREDIV_MIN > 0) begin : g_clamp
      always_comb eff = (prediv_in < PREDIV_W'(PREDIV_MIN)) ? PREDIV_W'(PREDIV_MIN) : prediv_in;
   end else begin : g_noclamp
      always_comb eff = prediv_in;
   end

   assign tick = run & (div_q == per_q - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= DIV_W'(2 * PREDIV_MIN + 2);
         div_q <= '0;
      end else if (load) begin
         per_q <= {1'b0, eff, 1'b0} + DIV_W'(2);
         div_q <= '0;
      end else if (run) begin
         div_q <= tick ? '0 : div_q + DIV_W'(1);
      end
   end

   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   a_r1_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (per_q >= DIV_W'(2 * PREDIV_MIN + 2)));

endmodule

// File: rtl/sent_status_flags.sv
`timescale 1ns/1ps
module sent_status_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ovv_in,
   input  logic take,
   input  logic abort,
   output logic pend_start,
   output logic pend_ovr
);
   logic ov_q, fr_start_q, fr_ovr_q, fall;

   assign fall = ov_q & ~ovv_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q       <= 1'b0;
         pend_start <= 1'b1;
         pend_ovr   <= 1'b0;
         fr_start_q <= 1'b0;
         fr_ovr_q   <= 1'b0;
      end else begin
         ov_q <= ovv_in;
         if (take) begin
            fr_start_q <= pend_start;
            fr_ovr_q   <= pend_ovr;
            pend_start <= 1'b0;
            pend_ovr   <= fall;
         end else if (abort) begin
            pend_start <= pend_start | fr_start_q;
            pend_ovr   <= pend_ovr | fr_ovr_q | fall;
         end else if (fall) begin
            pend_ovr   <= 1'b1;
         end
      end
   end

   a_r9_fall_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_q && !ovv_in) |=> pend_ovr);
   a_r8_startup_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !pend_start);

endmodule

// File: rtl/sent_nib_pack.sv
`timescale 1ns/1ps
module sent_nib_pack
   import sent_tx_pkg::*;
#(
   parameter int VAL_W  = 16,
   parameter int TEMP_W = 8,
   localparam int DATA_NIBS = (VAL_W + TEMP_W) / NIB_W,
   localparam int NIB_TOT   = DATA_NIBS + 2
) (
   input  logic [VAL_W-1:0]         value,
   input  logic [TEMP_W-1:0]        temp,
   input  logic [1:0]               range_in,
   input  logic                     flag_start,
   input  logic                     flag_ovr,
   output logic [NIB_TOT*NIB_W-1:0] nibs
);
   localparam int WORD_W = VAL_W + TEMP_W;

   if ((VAL_W % NIB_W) != 0 || (TEMP_W % NIB_W) != 0) begin : g_bad_w
      $error("value and temperature widths must be whole nibbles");
   end

   status_nib_t       st;
   logic [WORD_W-1:0] word;
   logic [3:0]        crc_c [0:DATA_NIBS+1];

   assign st.startup = flag_start;
   assign st.ovr_rec = flag_ovr;
   assign st.rng     = (range_in == 2'b10) ? 2'b01 : range_in;
   assign word       = {value, temp};

   assign nibs[0 +: NIB_W] = st;
   assign crc_c[0] = CRC_SEED;
   assign crc_c[1] = crc4_step(CRC_SEED, st);

   for (genvar i = 0; i < DATA_NIBS; i++) begin : g_data
      logic [3:0] d;
      assign d = word[WORD_W-1-i*NIB_W -: NIB_W];
      assign nibs[(i+1)*NIB_W +: NIB_W] = d;
      assign crc_c[i+2] = crc4_step(crc_c[i+1], d);
   end

   assign nibs[(NIB_TOT-1)*NIB_W +: NIB_W] = crc_c[DATA_NIBS+1];

endmodule

// File: rtl/sent_frame_tx.sv
`timescale 1ns/1ps
module sent_frame_tx #(
   parameter int VAL_W         = 16,
   parameter int TEMP_W        = 8,
   parameter int PREDIV_W      = 4,
   parameter int PREDIV_MIN    = 7,
   parameter int SYNC_UT       = 56,
   parameter int LOW_UT        = 3,
   parameter int NIB_BASE      = 12,
   parameter int READY_DLY_CYC = 720
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [VAL_W-1:0]    sample_value,
   input  logic [TEMP_W-1:0]   sample_temp,
   input  logic [1:0]          range_code,
   input  logic                ovv_in,
   input  logic                tx_off,
   input  logic [PREDIV_W-1:0] prediv,
   output logic                drv_low,
   output logic                sample_req
);
   localparam int DATA_NIBS = (VAL_W + TEMP_W) / 4;
   localparam int NIB_TOT   = DATA_NIBS + 2;
   localparam int PIDX_W    = $clog2(NIB_TOT + 1);
   localparam int UT_W      = $clog2(SYNC_UT + 1);
   localparam int RDY_W     = $clog2(READY_DLY_CYC + 1);

   if (SYNC_UT <= NIB_BASE + 15 || LOW_UT >= NIB_BASE || READY_DLY_CYC < 1) begin : g_bad_cfg
      $error("pulse timing parameters are inconsistent");
   end

   logic                     busy_q;
   logic [PIDX_W-1:0]        pidx_q;
   logic [UT_W-1:0]          ut_q, plen;
   logic [NIB_TOT*4-1:0]     nib_d, nib_q;
   logic [3:0]               cur_nib;
   logic                     tick, pulse_end, frame_end, start, enter_last;
   logic                     pend_start, pend_ovr;
   logic                     rdy_run;
   logic [RDY_W-1:0]         rdy_cnt;

   sent_ut_tick #(.PREDIV_W(PREDIV_W), .PREDIV_MIN(PREDIV_MIN)) tick_i (
      .clk(clk), .rst_n(rst_n), .load(start), .prediv_in(prediv),
      .run(busy_q), .tick(tick));

   sent_status_flags flags_i (
      .clk(clk), .rst_n(rst_n), .ovv_in(ovv_in), .take(start),
      .abort(tx_off & busy_q), .pend_start(pend_start), .pend_ovr(pend_ovr));

   sent_nib_pack #(.VAL_W(VAL_W), .TEMP_W(TEMP_W)) pack_i (
      .value(sample_value), .temp(sample_temp), .range_in(range_code),
      .flag_start(pend_start), .flag_ovr(pend_ovr), .nibs(nib_d));

   always_comb begin
      cur_nib = '0;
      for (int k = 0; k < NIB_TOT; k++)
         if (pidx_q == PIDX_W'(k + 1)) cur_nib = nib_q[k*4 +: 4];
   end

   assign plen       = (pidx_q == '0) ? UT_W'(SYNC_UT) : UT_W'(NIB_BASE) + UT_W'(cur_nib);
   assign pulse_end  = busy_q & tick & (ut_q == plen - UT_W'(1));
   assign frame_end  = pulse_end & (pidx_q == PIDX_W'(NIB_TOT));
   assign enter_last = pulse_end & (pidx_q == PIDX_W'(NIB_TOT - 1));
   assign start      = ~tx_off & (~busy_q | frame_end);
   assign drv_low    = busy_q & ~tx_off & (ut_q < UT_W'(LOW_UT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pidx_q <= '0;
         ut_q   <= '0;
         nib_q  <= '0;
      end else if (tx_off) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         pidx_q <= '0;
         ut_q   <= '0;
         nib_q  <= nib_d;
      end else if (pulse_end) begin
         pidx_q <= pidx_q + PIDX_W'(1);
         ut_q   <= '0;
      end else if (tick) begin
         ut_q   <= ut_q + UT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_run    <= 1'b0;
         rdy_cnt    <= '0;
         sample_req <= 1'b0;
      end else if (tx_off) begin
         rdy_run    <= 1'b0;
         sample_req <= 1'b0;
      end else begin
         sample_req <= 1'b0;
         if (enter_last) begin
            rdy_run <= 1'b1;
            rdy_cnt <= '0;
         end else if (rdy_run) begin
            if (rdy_cnt == RDY_W'(READY_DLY_CYC - 1)) begin
               rdy_run    <= 1'b0;
               sample_req <= 1'b1;
            end else begin
               rdy_cnt <= rdy_cnt + RDY_W'(1);
            end
         end
      end
   end

   a_r10_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
      tx_off |=> !busy_q);
   a_r3_ut_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (ut_q < plen));
   a_r2_low_at_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_low) |-> (ut_q == '0));
   a_r7_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !start && !tx_off) |=> $stable(nib_q));
   a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |=> !sample_req);
   a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (pidx_q <= PIDX_W'(NIB_TOT)));

endmodule

// File: tb/sent_frame_tx_tb.sv
`timescale 1ns/1ps
module sent_frame_tx_tb_top;
   localparam int DLY = 720;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sample_value = 16'hA5C3;
   logic [7:0]  sample_temp = 8'h7E;
   logic [1:0]  range_code = 2'b11;
   logic        ovv_in = 1'b0;
   logic        tx_off = 1'b0;
   logic [3:0]  prediv = 4'd11;
   logic        drv_low, sample_req;

   always #2 clk = ~clk;

   sent_frame_tx dut_i (
      .clk(clk), .rst_n(rst_n), .sample_value(sample_value), .sample_temp(sample_temp),
      .range_code(range_code), .ovv_in(ovv_in), .tx_off(tx_off), .prediv(prediv),
      .drv_low(drv_low), .sample_req(sample_req));

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   string scen = "R12 reset";

   int crc_tbl [16] = '{0,13,7,10,14,3,9,4,1,12,6,11,15,2,8,5};

   // behavioural reference
   int m_len [9];
   int m_P, m_tot, m_crcst, m_pos, m_rc = -1, m_frames = 0;
   bit m_busy, m_fs, m_fo, m_ps, m_po, m_ovprev, m_req;

   task automatic build_frame();
      int p, st, c, sum;
      int d [6];
      p = (prediv < 7) ? 7 : prediv;
      m_P = 2 * p + 2;
      st = (m_fs ? 8 : 0) + (m_fo ? 4 : 0) + ((range_code == 2) ? 1 : range_code);
      d[0] = sample_value[15:12]; d[1] = sample_value[11:8];
      d[2] = sample_value[7:4];   d[3] = sample_value[3:0];
      d[4] = sample_temp[7:4];    d[5] = sample_temp[3:0];
      c = crc_tbl[5 ^ st];
      for (int i = 0; i < 6; i++) c = crc_tbl[c ^ d[i]];
      m_len[0] = 56; m_len[1] = 12 + st; m_len[8] = 12 + c;
      for (int i = 0; i < 6; i++) m_len[i+2] = 12 + d[i];
      sum = 0;
      for (int k = 0; k < 8; k++) sum += m_len[k];
      m_crcst = sum * m_P;
      m_tot = (sum + m_len[8]) * m_P;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_ps = 1; m_po = 0; m_ovprev = 0; m_rc = -1; m_req = 0;
         m_fs = 0; m_fo = 0;
      end else begin : upd
         bit fall;
         fall = m_ovprev && !ovv_in;
         m_ovprev = ovv_in;
         m_req = 0;
         if (tx_off) begin
            if (m_busy) begin m_ps |= m_fs; m_po |= m_fo; end
            m_busy = 0; m_rc = -1;
         end else begin
            if (m_busy && m_pos == m_tot - 1) m_frames++;
            if (!m_busy || m_pos == m_tot - 1) begin
               m_fs = m_ps; m_fo = m_po; m_ps = 0; m_po = 0;
               build_frame();
               m_busy = 1; m_pos = 0;
            end else m_pos++;
            if (m_rc >= 0) begin
               m_rc++;
               if (m_rc == DLY) begin m_req = 1; m_rc = -1; end
            end
            if (m_pos == m_crcst) m_rc = 0;
         end
         if (fall) m_po = 1;
      end
   end

   function automatic int cur_pulse();
      int cum = 0;
      for (int k = 0; k < 9; k++) begin
         if (m_pos < (cum + m_len[k]) * m_P) return k;
         cum += m_len[k];
      end
      return 8;
   endfunction

   function automatic bit exp_low();
      int cum = 0;
      if (!rst_n || !m_busy || tx_off) return 0;
      for (int k = 0; k < 9; k++) begin
         if (m_pos < (cum + m_len[k]) * m_P) return (m_pos - cum * m_P) < 3 * m_P;
         cum += m_len[k];
      end
      return 0;
   endfunction

   function automatic string phase_tag();
      int k;
      if (!rst_n || !m_busy) return "R12";
      if (tx_off) return "R10";
      k = cur_pulse();
      if (k == 0) return "R3";
      if (k == 1) return "R5";
      if (k == 8) return "R6";
      return "R4";
   endfunction

   always @(negedge clk) begin
      if (!done) begin : cmp
         bit el, er;
         el = exp_low();
         er = rst_n ? m_req : 1'b0;
         n_cmp += 2;
         if (drv_low !== el) begin
            n_bad++;
            $display("FAIL %s [%s] cyc %0d drv_low actual %b expected %b", phase_tag(), scen, cyc, drv_low, el);
         end
         if (sample_req !== er) begin
            n_bad++;
            $display("FAIL R11 [%s] cyc %0d sample_req actual %b expected %b", scen, cyc, sample_req, er);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_frames(input int n);
      int target;
      target = m_frames + n;
      while (m_frames < target) step(1);
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      step(5);
      rst_n = 1'b1;
      // R12 then R2 R8 R10: abort the startup frame, flag must reappear
      scen = "R2 R8 R10 startup abort";
      step(1500);
      tx_off = 1'b1;
      step(20);
      tx_off = 1'b0;
      wait_frames(2);
      // R1 R7: clamped predivider, inputs changed inside a frame
      scen = "R1 R5 R7 clamp and hold";
      prediv = 4'd0; sample_value = 16'hFFFF; sample_temp = 8'h00; range_code = 2'b10;
      wait_frames(1);
      step(500);
      sample_value = 16'h1234; sample_temp = 8'h56; range_code = 2'b00; prediv = 4'd15;
      wait_frames(2);
      // R9: overvoltage recovery flag one-shot
      scen = "R9 R11 overvoltage recovery";
      prediv = 4'd7;
      ovv_in = 1'b1;
      step(50);
      ovv_in = 1'b0;
      wait_frames(3);
      // R6 R10: zero data, brief disable inside the calibration pulse
      scen = "R3 R6 R10 zero data";
      sample_value = 16'h0000; sample_temp = 8'h00; range_code = 2'b01;
      wait_frames(1);
      step(100);
      tx_off = 1'b1;
      step(3);
      tx_off = 1'b0;
      wait_frames(2);
      finish_run();
   end

   initial begin
      while (cyc < 180000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog [%s] actual timeout expected completion", scen);
      finish_run();
   end

endmodule